// File: doc/BRIEF.md
# Scan-to-Core Debug Bridge

This block connects a boundary-scan style host port to the halt and run controls of a processor core. The host selects one of four data registers with a 2-bit instruction code, then uses capture, shift and update strobes to read and write it serially, least-significant bit first. The four registers are an identification word, a control and status word, a 16-bit data exchange word and a procedure launch word. A single 16-bit value is written to the core's scratch register. A numbered debug procedure runs on the core with a one-cycle start strobe.

The scan side runs on its own clock, `tck`, and the core side runs on `clk`. Launches and value writes cross into the core domain through a toggle handshake. The halt request and the core reset request are level signals, each resynchronised with two flops. The core's stopped flag and its result word return to the scan domain through two-flop synchronisers.

A host halts the core by clearing the run bit, with the enable bit set, and then polls until the run bit reads 0. It may then write a value and launch procedures. It polls the valid flag of the data word to collect results. To resume, it sets the run bit and launches procedure 0.

Top module: `dbg_scan_bridge`

## Requirements
- R1: The instruction code selects the register and its scan length: 00 identification (32 bits), 01 control (17 bits), 10 data (17 bits), 11 launch (8 bits). Data shifts in and out least-significant bit first, with `tdo` showing bit 0 of the shift register. A bit shifted into `tdi` leaves on `tdo` after exactly that many shifts. A capture loads the selected register's contents, with reserved fields reading 0.
- R2: Capturing the identification register returns the parameter ID_VALUE. Bits shifted into it and updated have no effect on later reads.
- R3: Control bit 0 reads 1 while the synchronised stopped flag is low and 0 while it is high. An enabled update writing bit 0 as 0 raises `core_seize`; writing it as 1 lowers `core_seize`.
- R4: An enabled update of control bit 1 sets `core_reset` to the written value. Bit 1 reads back the written value, and bits 16:2 read as 0.
- R5: A control update with bit 16 at 0 changes neither `core_seize` nor `core_reset`.
- R6: A data update with bit 16 at 1 produces exactly one `clk` cycle of `wval_en`, with `wval` equal to bits 15:0. With bit 16 at 0 it produces no pulse.
- R7: Every launch update produces exactly one `clk` cycle of `proc_run`, with `proc_addr` equal to bits 7:0. `proc_addr` changes only in a `proc_run` cycle, and a capture of the launch register reads 0.
- R8: A data capture returns the synchronised `core_result` in bits 15:0 and a valid flag in bit 16. The flag clears at each launch and sets when the synchronised stopped flag rises.
- R9: After reset `core_seize`, `core_reset`, `proc_run` and `wval_en` are 0, and a data capture reads 0 while the core runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Scan-side asynchronous reset, active low |
| ir_sel | input | 2 | Instruction code selecting the data register |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Core-side asynchronous reset, active low |
| core_seize | output | 1 | Halt request to the core |
| core_reset | output | 1 | Reset request to the core |
| proc_addr | output | 8 | Debug procedure number |
| proc_run | output | 1 | One-cycle procedure start strobe |
| wval | output | 16 | Value for the core's scratch register |
| wval_en | output | 1 | One-cycle write strobe for `wval` |
| core_stopped | input | 1 | Core is halted and ready for debug |
| core_result | input | 16 | Result value from the core |

## Verification
The hardest state to reach is a data capture taken after a launch but before the core has finished. The valid flag must read 0 there, although the core's stopped flag may still be high for a few cycles. The bench reaches this by capturing the data register directly after a launch, while the modelled core is still working through its procedure. It then polls until the flag sets and compares the result against the value computed from the earlier write. A launch that follows a non-enabled data write shows that the scratch value was left untouched.

// File: rtl/dbg_bridge_pkg.sv
package dbg_bridge_pkg;
  typedef enum logic [1:0] {
    IR_IDENT = 2'b00,
    IR_CTRL  = 2'b01,
    IR_VALUE = 2'b10,
    IR_PROC  = 2'b11
  } ir_e;
endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d;
      s1_q <= s0_q;
    end
  end

  assign q = s1_q;
endmodule

// File: rtl/dbg_toggle_xfer.sv
module dbg_toggle_xfer #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_send,
  input  logic [W-1:0] src_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_data,
  output logic         dst_pulse
);
  logic [W-1:0] hold_q, hold_n;
  logic         tog_q, tog_n;
  logic         tog_s, seen_q, seen_n;
  logic [W-1:0] data_q, data_n;
  logic         pulse_q, pulse_n;
  logic         edge_det;

  // source side: latch payload, flip the request
  always_comb begin
    hold_n = hold_q;
    tog_n  = tog_q;
    if (src_send) begin
      hold_n = src_data;
      tog_n  = ~tog_q;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      hold_q <= hold_n;
      tog_q  <= tog_n;
    end
  end

  dbg_sync2 #(.W(1)) u_tsync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (tog_q),
    .q     (tog_s)
  );

  // destination side: a change of the synchronised toggle marks a transfer
  assign edge_det = tog_s ^ seen_q;

  always_comb begin
    seen_n  = tog_s;
    pulse_n = edge_det;
    data_n  = data_q;
    if (edge_det) data_n = hold_q;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
      data_q  <= '0;
    end else begin
      seen_q  <= seen_n;
      pulse_q <= pulse_n;
      data_q  <= data_n;
    end
  end

  assign dst_data  = data_q;
  assign dst_pulse = pulse_q;
endmodule

// File: rtl/dbg_scan_regs.sv
module dbg_scan_regs
  import dbg_bridge_pkg::*;
#(
  parameter int              VAL_W    = 16,
  parameter int              ADDR_W   = 8,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1DB0_5A4F
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [1:0]        ir_sel,
  input  logic              cap_en,
  input  logic              shift_en,
  input  logic              upd_en,
  input  logic              tdi,
  input  logic              stopped_s,
  input  logic [VAL_W-1:0]  result_s,
  output logic              tdo,
  output logic              seize_q,
  output logic              reset_q,
  output logic              val_send,
  output logic [VAL_W-1:0]  val_data,
  output logic              proc_send,
  output logic [ADDR_W-1:0] proc_data
);
  localparam int CTRL_LEN  = VAL_W + 1;
  localparam int VALUE_LEN = VAL_W + 1;
  localparam int PROC_LEN  = ADDR_W;
  localparam int ENA_BIT   = VAL_W;
  localparam int W_A       = (ID_W > VALUE_LEN) ? ID_W : VALUE_LEN;
  localparam int SR_W      = (W_A > PROC_LEN) ? W_A : PROC_LEN;

  ir_e             ir;
  logic [SR_W-1:0] sr_q, sr_n;
  logic [SR_W-1:0] cap_vec, shift_vec, shr;
  logic            seize_n, reset_n;
  logic            valid_q, valid_n;
  logic            stop_d_q;
  logic            upd_go;
  int              cur_len;

  assign ir = ir_e'(ir_sel);

  always_comb begin
    unique case (ir)
      IR_IDENT: cur_len = ID_W;
      IR_CTRL:  cur_len = CTRL_LEN;
      IR_VALUE: cur_len = VALUE_LEN;
      default:  cur_len = PROC_LEN;
    endcase
  end

  always_comb begin
    unique case (ir)
      IR_IDENT: cap_vec = SR_W'(ID_VALUE);
      IR_CTRL:  cap_vec = SR_W'({reset_q, ~stopped_s});
      IR_VALUE: cap_vec = SR_W'({valid_q, result_s});
      default:  cap_vec = '0;
    endcase
  end

  // shift toward bit 0; tdi enters at the top of the selected length
  assign shr = {1'b0, sr_q[SR_W-1:1]};
  always_comb begin
    for (int i = 0; i < SR_W; i++) begin
      if (i == cur_len - 1)    shift_vec[i] = tdi;
      else if (i < cur_len - 1) shift_vec[i] = shr[i];
      else                     shift_vec[i] = 1'b0;
    end
  end

  assign upd_go    = upd_en && !cap_en && !shift_en;
  assign proc_send = upd_go && (ir == IR_PROC);
  assign val_send  = upd_go && (ir == IR_VALUE) && sr_q[ENA_BIT];
  assign proc_data = sr_q[ADDR_W-1:0];
  assign val_data  = sr_q[VAL_W-1:0];
  assign tdo       = sr_q[0];

  always_comb begin
    sr_n    = sr_q;
    seize_n = seize_q;
    reset_n = reset_q;
    valid_n = valid_q;
    if (stopped_s && !stop_d_q) valid_n = 1'b1;
    if (cap_en)        sr_n = cap_vec;
    else if (shift_en) sr_n = shift_vec;
    else if (upd_en && ir == IR_CTRL && sr_q[ENA_BIT]) begin
      seize_n = ~sr_q[0];
      reset_n = sr_q[1];
    end
    if (proc_send) valid_n = 1'b0;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q     <= '0;
      seize_q  <= 1'b0;
      reset_q  <= 1'b0;
      valid_q  <= 1'b0;
      stop_d_q <= 1'b0;
    end else begin
      sr_q     <= sr_n;
      seize_q  <= seize_n;
      reset_q  <= reset_n;
      valid_q  <= valid_n;
      stop_d_q <= stopped_s;
    end
  end
endmodule

// File: rtl/dbg_scan_bridge.sv
module dbg_scan_bridge #(
  parameter int              VAL_W    = 16,
  parameter int              ADDR_W   = 8,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1DB0_5A4F
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [1:0]        ir_sel,
  input  logic              cap_en,
  input  logic              shift_en,
  input  logic              upd_en,
  input  logic              tdi,
  output logic              tdo,
  input  logic              clk,
  input  logic              rst_n,
  output logic              core_seize,
  output logic              core_reset,
  output logic [ADDR_W-1:0] proc_addr,
  output logic              proc_run,
  output logic [VAL_W-1:0]  wval,
  output logic              wval_en,
  input  logic              core_stopped,
  input  logic [VAL_W-1:0]  core_result
);
  logic              stopped_s;
  logic [VAL_W-1:0]  result_s;
  logic              seize_q, reset_q;
  logic              val_send, proc_send;
  logic [VAL_W-1:0]  val_data;
  logic [ADDR_W-1:0] proc_data;
  logic [1:0]        lvl_s;

  dbg_sync2 #(.W(1)) u_stop_sync (
    .clk (tck), .rst_n (trst_n), .d (core_stopped), .q (stopped_s)
  );

  dbg_sync2 #(.W(VAL_W)) u_res_sync (
    .clk (tck), .rst_n (trst_n), .d (core_result), .q (result_s)
  );

  dbg_scan_regs #(
    .VAL_W (VAL_W), .ADDR_W (ADDR_W), .ID_W (ID_W), .ID_VALUE (ID_VALUE)
  ) u_scan (
    .tck       (tck),
    .trst_n    (trst_n),
    .ir_sel    (ir_sel),
    .cap_en    (cap_en),
    .shift_en  (shift_en),
    .upd_en    (upd_en),
    .tdi       (tdi),
    .stopped_s (stopped_s),
    .result_s  (result_s),
    .tdo       (tdo),
    .seize_q   (seize_q),
    .reset_q   (reset_q),
    .val_send  (val_send),
    .val_data  (val_data),
    .proc_send (proc_send),
    .proc_data (proc_data)
  );

  dbg_sync2 #(.W(2)) u_lvl_sync (
    .clk (clk), .rst_n (rst_n), .d ({reset_q, seize_q}), .q (lvl_s)
  );
  assign core_seize = lvl_s[0];
  assign core_reset = lvl_s[1];

  dbg_toggle_xfer #(.W(ADDR_W)) u_proc_xfer (
    .src_clk   (tck),
    .src_rst_n (trst_n),
    .src_send  (proc_send),
    .src_data  (proc_data),
    .dst_clk   (clk),
    .dst_rst_n (rst_n),
    .dst_data  (proc_addr),
    .dst_pulse (proc_run)
  );

  dbg_toggle_xfer #(.W(VAL_W)) u_val_xfer (
    .src_clk   (tck),
    .src_rst_n (trst_n),
    .src_send  (val_send),
    .src_data  (val_data),
    .dst_clk   (clk),
    .dst_rst_n (rst_n),
    .dst_data  (wval),
    .dst_pulse (wval_en)
  );
endmodule

// File: rtl/dbg_scan_bridge_chk.sv
module dbg_scan_bridge_chk #(
  parameter int              VAL_W    = 16,
  parameter int              ADDR_W   = 8,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1DB0_5A4F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tck,
  input logic              trst_n,
  input logic [1:0]        ir_sel,
  input logic              cap_en,
  input logic              tdo,
  input logic [ADDR_W-1:0] proc_addr,
  input logic              proc_run,
  input logic [VAL_W-1:0]  wval,
  input logic              wval_en
);
  // R7: launch strobe lasts one core cycle
  a_r7_run_single: assert property (@(posedge clk) disable iff (!rst_n)
    proc_run |=> !proc_run);

  // R6: value write strobe lasts one core cycle
  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wval_en |=> !wval_en);

  // R7: procedure number moves only together with the strobe
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(proc_addr) |-> proc_run);

  // R6: value moves only together with its strobe
  a_r6_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wval) |-> wval_en);

  // R2: identification capture presents its first bit
  a_r2_ident_lsb: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_en && ir_sel == 2'b00) |=> (tdo == ID_VALUE[0]));

  // R7: launch register reads zero
  a_r7_proc_reads_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_en && ir_sel == 2'b11) |=> !tdo);
endmodule

bind dbg_scan_bridge dbg_scan_bridge_chk #(
  .VAL_W (VAL_W), .ADDR_W (ADDR_W), .ID_W (ID_W), .ID_VALUE (ID_VALUE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tck       (tck),
  .trst_n    (trst_n),
  .ir_sel    (ir_sel),
  .cap_en    (cap_en),
  .tdo       (tdo),
  .proc_addr (proc_addr),
  .proc_run  (proc_run),
  .wval      (wval),
  .wval_en   (wval_en)
);

// File: tb/sim_dbg_scan_bridge.sv
module sim_dbg_scan_bridge;
  localparam logic [31:0] IDV = 32'h1DB0_5A4F;

  logic        tck = 1'b0, clk = 1'b0;
  logic        trst_n, rst_n;
  logic [1:0]  ir_sel;
  logic        cap_en, shift_en, upd_en, tdi, tdo;
  logic        core_seize, core_reset, proc_run, wval_en, core_stopped;
  logic [7:0]  proc_addr;
  logic [15:0] wval, core_result;

  int n_chk = 0, n_bad = 0, n_wpulse = 0;
  bit done = 0;
  logic [7:0]  q_proc[$];
  logic [15:0] q_val[$];

  always #4  clk = ~clk;   // 125 MHz core clock
  always #20 tck = ~tck;

  dbg_scan_bridge u0 (
    .tck (tck), .trst_n (trst_n), .ir_sel (ir_sel), .cap_en (cap_en),
    .shift_en (shift_en), .upd_en (upd_en), .tdi (tdi), .tdo (tdo),
    .clk (clk), .rst_n (rst_n), .core_seize (core_seize),
    .core_reset (core_reset), .proc_addr (proc_addr), .proc_run (proc_run),
    .wval (wval), .wval_en (wval_en), .core_stopped (core_stopped),
    .core_result (core_result)
  );

  // behavioural core: halts on seize, runs procedures for ten cycles
  logic        m_stopped;
  int          m_busy;
  logic [15:0] m_tmp, m_res;
  logic [7:0]  m_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stopped <= 1'b0; m_busy <= 0; m_tmp <= '0; m_res <= '0; m_addr <= '0;
    end else begin
      if (wval_en) m_tmp <= wval;
      if (m_busy > 0) begin
        m_busy <= m_busy - 1;
        if (m_busy == 4) m_res <= m_tmp + 16'(m_addr);
        if (m_busy == 1) m_stopped <= 1'b1;
      end else if (m_stopped) begin
        if (proc_run) begin
          m_stopped <= 1'b0;
          m_addr    <= proc_addr;
          if (proc_addr != 8'h00 || core_seize) m_busy <= 10;
        end
      end else if (core_seize) m_stopped <= 1'b1;
    end
  end
  assign core_stopped = m_stopped;
  assign core_result  = m_res;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison of core-side strobes against expected queues
  logic prev_run = 1'b0, prev_wen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (proc_run) begin
        if (prev_run) chk("R7 run width", 1, 0);
        if (q_proc.size() == 0) chk("R7 unexpected launch", {56'h0, proc_addr}, 64'hFFFF);
        else chk("R7 launch addr", {56'h0, proc_addr}, {56'h0, q_proc.pop_front()});
      end
      if (wval_en) begin
        n_wpulse++;
        if (prev_wen) chk("R6 write width", 1, 0);
        if (q_val.size() == 0) chk("R6 unexpected write", {48'h0, wval}, 64'hFFFFF);
        else chk("R6 write value", {48'h0, wval}, {48'h0, q_val.pop_front()});
      end
      prev_run <= proc_run;
      prev_wen <= wval_en;
    end
  end

  task automatic scan_op(input logic [1:0] ir, input int n,
                         input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    @(negedge tck); ir_sel = ir; cap_en = 1'b1;
    @(negedge tck); cap_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_en = 1'b1; tdi = din[i]; dout[i] = tdo;
      @(negedge tck);
    end
    shift_en = 1'b0; upd_en = 1'b1;
    @(negedge tck); upd_en = 1'b0;
  endtask

  task automatic tck_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge tck);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    int w0;
    trst_n = 0; rst_n = 0; ir_sel = 0; cap_en = 0; shift_en = 0; upd_en = 0; tdi = 0;
    #200; @(negedge tck); trst_n = 1; rst_n = 1;
    tck_wait(4);

    // R9 reset state
    chk("R9 seize", core_seize, 0);
    chk("R9 reset", core_reset, 0);
    chk("R9 run strobe", proc_run, 0);
    chk("R9 write strobe", wval_en, 0);
    scan_op(2'b10, 17, 64'h0, d);
    chk("R9 data reads zero", d[16:0], 0);

    // R2 identification, then overwrite attempt
    scan_op(2'b00, 32, 64'hFFFF_FFFF, d);
    chk("R2 ident", d[31:0], IDV);
    scan_op(2'b00, 32, 64'h0, d);
    chk("R2 ident unchanged", d[31:0], IDV);

    // R1 lengths: tdi reappears after the register length
    scan_op(2'b00, 40, 64'hA5_0000_0000 | 64'hA5, d);
    chk("R1 ident length", d[39:32], 8'hA5);
    scan_op(2'b01, 20, 64'h5, d);
    chk("R1 control length", d[19:17], 3'b101);
    chk("R3 running reads run=1", d[16:0], 17'h00001);

    // R3 halt
    scan_op(2'b01, 17, 64'h10000, d);
    tck_wait(2);
    chk("R3 seize raised", core_seize, 1);
    for (int k = 0; k < 40; k++) begin
      scan_op(2'b01, 17, 64'h0, d);
      if (d[0] == 1'b0) break;
    end
    chk("R3 halted reads run=0", d[0], 0);

    // R6 value write, R7/R8 launch and result
    q_val.push_back(16'h1234);
    scan_op(2'b10, 17, 64'h11234, d);
    tck_wait(3);
    q_proc.push_back(8'h05);
    scan_op(2'b11, 8, 64'h05, d);
    scan_op(2'b10, 17, 64'h0, d);
    chk("R8 valid cleared after launch", d[16], 0);
    for (int k = 0; k < 40; k++) begin
      scan_op(2'b10, 17, 64'h0, d);
      if (d[16]) break;
    end
    chk("R8 result valid", d[16:0], 17'h11239);

    // wrap-around pattern
    q_val.push_back(16'hFFF0);
    scan_op(2'b10, 17, 64'h1FFF0, d);
    tck_wait(3);
    q_proc.push_back(8'h20);
    scan_op(2'b11, 8, 64'h20, d);
    for (int k = 0; k < 40; k++) begin
      scan_op(2'b10, 17, 64'h0, d);
      if (d[16]) break;
    end
    chk("R8 result wrap", d[16:0], 17'h10010);

    // R6 write with flag clear is discarded
    w0 = n_wpulse;
    scan_op(2'b10, 17, 64'h0BEEF, d);
    tck_wait(6);
    chk("R6 no pulse without flag", n_wpulse, w0);
    q_proc.push_back(8'h01);
    scan_op(2'b11, 8, 64'h01, d);
    for (int k = 0; k < 40; k++) begin
      scan_op(2'b10, 17, 64'h0, d);
      if (d[16]) break;
    end
    chk("R6 scratch kept", d[16:0], 17'h1FFF1);

    // R4 reset control
    scan_op(2'b01, 17, 64'h10002, d);
    tck_wait(2);
    chk("R4 reset raised", core_reset, 1);
    scan_op(2'b01, 17, 64'h0, d);
    chk("R4 readback", d[16:0], 17'h00002);
    scan_op(2'b01, 17, 64'h10000, d);
    tck_wait(2);
    chk("R4 reset released", core_reset, 0);

    // R5 update without enable
    scan_op(2'b01, 17, 64'h00003, d);
    tck_wait(3);
    chk("R5 seize kept", core_seize, 1);
    chk("R5 reset kept", core_reset, 0);
    scan_op(2'b01, 17, 64'h0, d);
    chk("R5 status unchanged", d[16:0], 17'h00000);

    // R3 resume: run bit then procedure 0
    scan_op(2'b01, 17, 64'h10001, d);
    tck_wait(2);
    chk("R3 seize lowered", core_seize, 0);
    q_proc.push_back(8'h00);
    scan_op(2'b11, 8, 64'h00, d);
    for (int k = 0; k < 40; k++) begin
      scan_op(2'b01, 17, 64'h0, d);
      if (d[0]) break;
    end
    chk("R3 running again", d[0], 1);

    tck_wait(4);
    chk("R7 all launches seen", q_proc.size(), 0);
    chk("R6 all writes seen", q_val.size(), 0);
    finish_run();
  end
endmodule